// File: doc/BRIEF.md
# Run-Time Configurable CRC Step Unit

This block performs one CRC update on a short chunk of data. Everything that shapes the update comes from a packed 32-bit control word sampled together with the operands: the CRC width (1 to 16 bits), the generator polynomial, the chunk length (1 to 8 bits), the bit order of the chunk and whether the seed and result are complemented. One operation is a pure function of three 32-bit words: control, data and seed. The answer is the new n-bit remainder, zero-extended to 32 bits.

The core works serially and consumes one data bit per clock. A `start` pulse captures the operands, and the first division step is taken in that same edge. `done` pulses when the last step has been taken. The remainder stays on `crc_out` until the next operation completes. A caller that streams a message feeds each result back as the seed of the next step.

Top module: `crcn_step_unit`

## Requirements
- R1: The CRC width n equals control bits [15:12] plus one, giving 1 to 16. Every `crc_out` bit at position n and above reads zero.
- R2: The generator is the n-bit field of the control word that starts at bit 16. Control bits above bit 16+n-1 have no effect on the result.
- R3: The chunk length m equals control bits [2:0] plus one. Data bits at position m and above are ignored. Control bits 3 to 7, 10 and 11 have no effect.
- R4: When control bit 8 is set, the m-bit chunk is bit-reversed before any other use: bit i moves to bit m-1-i.
- R5: When control bit 9 is set, the n-bit seed is complemented before use, and the final n-bit remainder is complemented before output.
- R6: The starting remainder is the seed XOR the chunk aligned to n bits. The chunk is shifted right by m-n when m exceeds n, and left by n-m otherwise.
- R7: Each of the m steps works the same way. The remainder shifts left by one. Its new LSB is the next bit of the chunk shifted left by n, taken at position m-1, and that stream shifts left once per step. If the old bit n-1 of the remainder was set, the shifted value is XORed with the generator.
- R8: `start` is accepted in a cycle where `busy` is low. `done` is then high for one cycle, exactly m cycles after the accepting cycle. `busy` is high in the cycles between, and low in the `done` cycle.
- R9: A `start` that arrives while `busy` is high is ignored. The operation in flight keeps its operands and its timing.
- R10: After reset, `busy`, `done` and `crc_out` are all zero.
- R11: `crc_out` changes only in a cycle where `done` is high. In every other cycle it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new step; operands sampled when accepted |
| ctl_word | input | 32 | Packed width, generator, chunk length, order and inversion |
| data_word | input | 32 | Chunk source; low m bits used |
| seed_word | input | 32 | Incoming remainder; low n bits used |
| busy | output | 1 | An operation is still taking steps |
| done | output | 1 | One-cycle pulse: `crc_out` holds a new result |
| crc_out | output | 32 | Latest remainder, zero-extended |

## Verification
The awkward cases are the chunks longer than the CRC width. Only there does the serial stream feed real data bits into the remainder; for every other chunk it feeds zeros. Such a chunk needs n below m, and the sweep reaches these pairs by walking every width against every chunk length, in each bit order and each inversion setting. Random polynomials, seeds and junk in the ignored fields go with each pair. The timing rules are reached with back-to-back single-bit operations, with a new start in the very cycle that `done` pulses, and with `start` held high through a long operation.

// File: rtl/crcn_pkg.sv
`timescale 1ns / 1ps
package crcn_pkg;
  localparam int WORD_W       = 32;
  // control word layout (positions are decoded by the step logic)
  localparam int CTL_M_LSB    = 0;
  localparam int CTL_M_W      = 3;
  localparam int CTL_REV_BIT  = 8;
  localparam int CTL_INV_BIT  = 9;
  localparam int CTL_N_LSB    = 12;
  localparam int CTL_N_W      = 4;
  localparam int CTL_POLY_LSB = 16;
  // derived sizes
  localparam int CRC_MAX  = 1 << CTL_N_W;
  localparam int DATA_MAX = 1 << CTL_M_W;
  localparam int STRM_W   = CRC_MAX + DATA_MAX;
  localparam int STRM_IW  = $clog2(STRM_W);

  typedef logic [CRC_MAX-1:0]  rem_t;
  typedef logic [DATA_MAX-1:0] dat_t;
  typedef logic [STRM_W-1:0]   strm_t;
  typedef logic [CTL_N_W-1:0]  nsel_t;
  typedef logic [CTL_M_W-1:0]  msel_t;

  typedef struct packed {
    nsel_t n_m1;
    msel_t m_m1;
    rem_t  poly;
    logic  rev;
    logic  inv;
  } crc_cfg_t;

  // low n bits set, n = n_m1 + 1
  function automatic rem_t width_mask(input nsel_t n_m1);
    rem_t msk;
    for (int i = 0; i < CRC_MAX; i++) msk[i] = (i <= int'(n_m1));
    return msk;
  endfunction

  // low m bits set, m = m_m1 + 1
  function automatic dat_t chunk_mask(input msel_t m_m1);
    dat_t msk;
    for (int i = 0; i < DATA_MAX; i++) msk[i] = (i <= int'(m_m1));
    return msk;
  endfunction

  // mirror the low m bits of a chunk
  function automatic dat_t reverse_chunk(input dat_t d, input msel_t m_m1);
    dat_t r;
    r = '0;
    for (int i = 0; i < DATA_MAX; i++)
      if (i <= int'(m_m1)) r[i] = d[CTL_M_W'(int'(m_m1) - i)];
    return r;
  endfunction

  // place the chunk against the top of an n-bit remainder
  function automatic rem_t align_chunk(input dat_t d, input nsel_t n_m1, input msel_t m_m1);
    rem_t wide;
    wide = rem_t'(d);
    if (int'(m_m1) > int'(n_m1)) return wide >> (int'(m_m1) - int'(n_m1));
    return wide << (int'(n_m1) - int'(m_m1));
  endfunction

  // one serial division step
  function automatic rem_t crc_bit_step(input rem_t r, input rem_t poly,
                                        input nsel_t n_m1, input logic inb);
    rem_t nx;
    nx = {r[CRC_MAX-2:0], inb};
    if (r[n_m1]) nx = nx ^ poly;
    return nx & width_mask(n_m1);
  endfunction

  // optional complement, truncate, zero-extend
  function automatic logic [WORD_W-1:0] finish_crc(input rem_t r, input nsel_t n_m1,
                                                   input logic inv);
    rem_t v;
    v = inv ? ~r : r;
    v = v & width_mask(n_m1);
    return WORD_W'(v);
  endfunction
endpackage

// File: rtl/crcn_ctl_decode.sv
`timescale 1ns / 1ps
module crcn_ctl_decode
  import crcn_pkg::*;
(
  input  logic [WORD_W-1:0] ctl_word,
  output crc_cfg_t          cfg
);
  nsel_t n_m1;
  logic  unused_ctl;

  assign n_m1 = ctl_word[CTL_N_LSB +: CTL_N_W];

  always_comb begin
    cfg.n_m1 = n_m1;
    cfg.m_m1 = ctl_word[CTL_M_LSB +: CTL_M_W];
    cfg.poly = ctl_word[CTL_POLY_LSB +: CRC_MAX] & width_mask(n_m1);
    cfg.rev  = ctl_word[CTL_REV_BIT];
    cfg.inv  = ctl_word[CTL_INV_BIT];
  end

  assign unused_ctl = ^{ctl_word[CTL_REV_BIT-1:CTL_M_LSB+CTL_M_W],
                        ctl_word[CTL_N_LSB-1:CTL_INV_BIT+1]};
endmodule

// File: rtl/crcn_operand_prep.sv
`timescale 1ns / 1ps
module crcn_operand_prep
  import crcn_pkg::*;
(
  input  crc_cfg_t          cfg,
  input  logic [WORD_W-1:0] data_word,
  input  logic [WORD_W-1:0] seed_word,
  output rem_t              init_rem,
  output strm_t             init_strm
);
  dat_t chunk_raw;
  dat_t chunk;
  rem_t seed_n;
  logic unused_hi;

  assign chunk_raw = data_word[DATA_MAX-1:0] & chunk_mask(cfg.m_m1);
  assign chunk     = cfg.rev ? reverse_chunk(chunk_raw, cfg.m_m1) : chunk_raw;
  assign seed_n    = (seed_word[CRC_MAX-1:0] ^ {CRC_MAX{cfg.inv}}) & width_mask(cfg.n_m1);
  assign init_rem  = align_chunk(chunk, cfg.n_m1, cfg.m_m1) ^ seed_n;
  assign init_strm = strm_t'(chunk) << (int'(cfg.n_m1) + 1);

  assign unused_hi = ^{data_word[WORD_W-1:DATA_MAX], seed_word[WORD_W-1:CRC_MAX]};
endmodule

// File: rtl/crcn_bit_step.sv
`timescale 1ns / 1ps
module crcn_bit_step
  import crcn_pkg::*;
(
  input  rem_t  rem_in,
  input  rem_t  poly,
  input  nsel_t n_m1,
  input  logic  in_bit,
  output rem_t  rem_out
);
  assign rem_out = crc_bit_step(rem_in, poly, n_m1, in_bit);
endmodule

// File: rtl/crcn_step_unit.sv
`timescale 1ns / 1ps
module crcn_step_unit
  import crcn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [WORD_W-1:0] data_word,
  input  logic [WORD_W-1:0] seed_word,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] crc_out
);
  crc_cfg_t dec_cfg;
  rem_t     prep_rem;
  strm_t    prep_strm;

  // latched operation
  nsel_t n_q;
  msel_t m_q;
  rem_t  poly_q;
  logic  inv_q;
  rem_t  rem_q;
  strm_t strm_q;
  msel_t left_q;
  logic  busy_q;
  logic  done_q;
  logic [WORD_W-1:0] res_q;

  // named events
  logic  accept;
  logic  step_en;
  logic  last_step;
  nsel_t step_n;
  msel_t step_m;
  rem_t  step_poly;
  logic  step_inv;
  rem_t  step_rem_in;
  rem_t  step_rem_out;
  strm_t step_strm;
  logic  step_in_bit;
  nsel_t act_n_m1;

  crcn_ctl_decode u_dec (
    .ctl_word (ctl_word),
    .cfg      (dec_cfg)
  );

  crcn_operand_prep u_prep (
    .cfg       (dec_cfg),
    .data_word (data_word),
    .seed_word (seed_word),
    .init_rem  (prep_rem),
    .init_strm (prep_strm)
  );

  assign accept      = start & ~busy_q;
  assign step_en     = accept | busy_q;
  assign step_n      = accept ? dec_cfg.n_m1 : n_q;
  assign step_m      = accept ? dec_cfg.m_m1 : m_q;
  assign step_poly   = accept ? dec_cfg.poly : poly_q;
  assign step_inv    = accept ? dec_cfg.inv  : inv_q;
  assign step_rem_in = accept ? prep_rem     : rem_q;
  assign step_strm   = accept ? prep_strm    : strm_q;
  assign step_in_bit = step_strm[STRM_IW'(step_m)];
  assign last_step   = accept ? (dec_cfg.m_m1 == '0) : (left_q == CTL_M_W'(1));
  assign act_n_m1    = n_q;

  crcn_bit_step u_step (
    .rem_in  (step_rem_in),
    .poly    (step_poly),
    .n_m1    (step_n),
    .in_bit  (step_in_bit),
    .rem_out (step_rem_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= '0;
      m_q    <= '0;
      poly_q <= '0;
      inv_q  <= 1'b0;
      rem_q  <= '0;
      strm_q <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (step_en) begin
        rem_q  <= step_rem_out;
        strm_q <= step_strm << 1;
        if (accept) begin
          n_q    <= dec_cfg.n_m1;
          m_q    <= dec_cfg.m_m1;
          poly_q <= dec_cfg.poly;
          inv_q  <= dec_cfg.inv;
          left_q <= dec_cfg.m_m1;
        end else begin
          left_q <= left_q - CTL_M_W'(1);
        end
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= finish_crc(step_rem_out, step_n, step_inv);
        end else begin
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign crc_out = res_q;
endmodule

// File: rtl/crcn_step_chk.sv
`timescale 1ns / 1ps
module crcn_step_chk
  import crcn_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input msel_t             ctl_m_m1,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] crc_out,
  input nsel_t             act_n_m1,
  input msel_t             steps_left
);
  // cycles until the accepted operation is due
  logic [CTL_M_W:0] due_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) due_cnt <= '0;
    else if (start && !busy) due_cnt <= {1'b0, ctl_m_m1} + (CTL_M_W+1)'(1);
    else if (due_cnt != '0) due_cnt <= due_cnt - (CTL_M_W+1)'(1);
  end

  p_done_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (due_cnt == (CTL_M_W+1)'(1)) |-> done);

  p_done_only_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (due_cnt == (CTL_M_W+1)'(1)));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(act_n_m1));

  p_hold_output_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(crc_out));

  p_width_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((crc_out >> (int'(act_n_m1) + 1)) == '0));

  p_steps_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (steps_left != '0));
endmodule

bind crcn_step_unit crcn_step_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .ctl_m_m1   (ctl_word[2:0]),
  .busy       (busy),
  .done       (done),
  .crc_out    (crc_out),
  .act_n_m1   (act_n_m1),
  .steps_left (left_q)
);

// File: tb/crcn_step_unit_tb.sv
`timescale 1ns / 1ps
module crcn_step_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctl = '0;
  logic [31:0] dat = '0;
  logic [31:0] sd = '0;
  logic        busy;
  logic        done;
  logic [31:0] crc_out;

  crcn_step_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ctl_word  (ctl),
    .data_word (dat),
    .seed_word (sd),
    .busy      (busy),
    .done      (done),
    .crc_out   (crc_out)
  );

  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  string phase = "R10";

  // behavioural model state
  bit          m_busy = 1'b0;
  bit          m_done = 1'b0;
  int          m_left = 0;
  logic [31:0] m_val = '0;
  logic [31:0] m_out = '0;

  // R1..R7 restated with plain integers
  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d,
                                          input logic [31:0] s);
    int n, m;
    logic [31:0] msk, g, x, r, sv;
    logic inb, hi;
    n = int'(c[15:12]) + 1;
    m = int'(c[2:0]) + 1;
    msk = (32'd1 << n) - 32'd1;
    g = (c >> 16) & msk;
    x = d & ((32'd1 << m) - 32'd1);
    if (c[8]) begin
      r = '0;
      for (int i = 0; i < m; i++) if (((x >> i) & 32'd1) != 0) r = r | (32'd1 << (m - 1 - i));
      x = r;
    end
    sv = s & msk;
    if (c[9]) sv = sv ^ msk;
    r = (m > n) ? (x >> (m - n)) : (x << (n - m));
    r = r ^ sv;
    for (int i = 0; i < m; i++) begin
      inb = (i + n < m) ? (((x >> (m - 1 - n - i)) & 32'd1) != 0) : 1'b0;
      hi = ((r >> (n - 1)) & 32'd1) != 0;
      r = ((r << 1) | {31'd0, inb}) & msk;
      if (hi) r = r ^ g;
    end
    if (c[9]) r = ~r & msk;
    return r;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  // one clock: drive, model the edge, compare away from the edge
  task automatic cyc(input bit st, input logic [31:0] c, input logic [31:0] d,
                     input logic [31:0] s);
    start = st; ctl = c; dat = d; sd = s;
    @(posedge clk);
    m_done = 1'b0;
    if (st && !m_busy) begin
      m_val = ref_crc(c, d, s);
      if (c[2:0] == 3'd0) begin
        m_done = 1'b1;
        m_out = m_val;
      end else begin
        m_busy = 1'b1;
        m_left = int'(c[2:0]);
      end
    end else if (m_busy) begin
      m_left--;
      if (m_left == 0) begin
        m_busy = 1'b0;
        m_done = 1'b1;
        m_out = m_val;
      end
    end
    @(negedge clk);
    check("busy", {31'd0, busy}, {31'd0, m_busy});
    check("done", {31'd0, done}, {31'd0, m_done});
    check("crc_out", crc_out, m_out);
  endtask

  task automatic run_op(input logic [31:0] c, input logic [31:0] d, input logic [31:0] s);
    cyc(1'b1, c, d, s);
    while (m_busy) cyc(1'b0, $urandom, $urandom, $urandom);
  endtask

  function automatic logic [31:0] mk_ctl(input int n, input int m, input bit rv, input bit iv);
    logic [31:0] c;
    c = ($urandom & 32'hFFFF_0000) | ($urandom & 32'h0000_0CF8);
    c = c | (32'(n - 1) << 12) | 32'(m - 1) | (32'(rv) << 8) | (32'(iv) << 9);
    return c;
  endfunction

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    phase = "R10";
    check("busy", {31'd0, busy}, 32'd0);
    check("done", {31'd0, done}, 32'd0);
    check("crc_out", crc_out, 32'd0);

    // full sweep of width, chunk, order and inversion
    for (int n = 1; n <= 16; n++)
      for (int m = 1; m <= 8; m++)
        for (int rv = 0; rv < 2; rv++)
          for (int iv = 0; iv < 2; iv++) begin
            if (rv == 0 && iv == 0) phase = "R1,R3,R6,R7";
            else if (iv == 0) phase = "R4";
            else phase = "R5";
            run_op(mk_ctl(n, m, bit'(rv), bit'(iv)), $urandom, $urandom);
          end

    // R2 generators with junk above the field
    phase = "R2";
    for (int k = 0; k < 40; k++)
      run_op(mk_ctl((k % 16) + 1, 8, 1'b0, 1'b0), $urandom, $urandom);

    // R3 same chunk with different upper data bits
    phase = "R3";
    for (int k = 0; k < 10; k++) begin
      run_op(mk_ctl(3, 8, 1'b0, 1'b0) & 32'hFFFF_F007, 32'h0000_00A5, 32'h5);
      run_op(mk_ctl(3, 8, 1'b0, 1'b0), $urandom & 32'hFFFF_FF00 | 32'hA5, 32'hFFFF_FFF5);
    end

    // R8 back-to-back single-bit steps and starts in the done cycle
    phase = "R8";
    for (int k = 0; k < 20; k++) cyc(1'b1, mk_ctl((k % 16) + 1, 1, 1'b0, bit'(k & 1)), $urandom, $urandom);
    for (int k = 0; k < 12; k++) run_op(mk_ctl(16 - k, (k % 8) + 1, bit'(k & 1), 1'b0), $urandom, $urandom);

    // R9 start held high through long operations
    phase = "R9";
    for (int k = 0; k < 6; k++) begin
      cyc(1'b1, mk_ctl(k + 2, 8, 1'b0, 1'b1), $urandom, $urandom);
      while (m_busy) cyc(1'b1, mk_ctl(9, 2, 1'b1, 1'b0), $urandom, $urandom);
    end

    // R11 idle with moving inputs
    phase = "R11";
    for (int k = 0; k < 24; k++) cyc(1'b0, $urandom, $urandom, $urandom);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule